// File: doc/BRIEF.md
# Rotating Three-Bank Fill Cache

This block manages three SRAM banks that sit between a slow, burst-oriented DRAM fill path and a rendering pipeline that must never stall. At any time two banks serve reads and the third takes incoming sub-cube words. The read side names the bank and the word address it wants, usually from an external mapping table, and gets the word one cycle later. The fill side streams words, one per accepted beat, into the bank that is currently writable. It can mark a whole sub-cube as already cached, and then the block drops that sub-cube.

The roles move when the reader first asks for the bank that is being filled. That bank joins the readable pair, and the next bank in the fixed cycle 2, 1, 0, 2 becomes writable. The fill pointer then restarts at address 0 of that bank, and whatever it held before is overwritten. A role state machine tracks which bank is writable. It has three states: `ROLE_W2` (the reset state), `ROLE_W1` and `ROLE_W0`. Each rotation takes it to the next state: `ROLE_W2`→`ROLE_W1`→`ROLE_W0`→`ROLE_W2`. A fill state machine handles the fill side. It has four states:
- `F_EDGE`: waiting for the first word of a sub-cube.
- `F_KEEP`: inside a sub-cube that is being written.
- `F_DROP`: inside a sub-cube that is being discarded.
- `F_FULL`: the bank is full.

Its transitions are:
- edge→keep on a first word without skip.
- edge→drop on a first word with skip.
- keep/drop→edge on the last word of a sub-cube.
- keep→full when the last bank address is written.
- any state→edge on a rotation.

Top module: `tribank_fill_cache`

## Requirements
- R1: After reset, bank 2 is writable (`bank_wr_sel` = 2), banks 0 and 1 are readable (`bank_rd_ok` = 3'b011), `rd_valid` is 0 and `wr_ready` is 1.
- R2: Exactly two bits of `bank_rd_ok` are set at all times. Bit i is set when bank i is readable, and the bit at index `bank_wr_sel` is clear.
- R3: A request with `rd_bank` equal to a readable bank raises `rd_valid` in the next cycle. `rd_data` then carries the last word written to that bank at `rd_addr`.
- R4: A request with `rd_bank` equal to the writable bank rotates the roles at that clock edge. The writable bank moves 2→1→0→2, and the previously writable bank becomes readable. `rot_evt` is high for exactly the one cycle after the edge. The requested word is returned one cycle later, with the same latency as any read.
- R5: A request with `rd_bank` = 3 is ignored. No `rd_valid` follows and the roles do not change.
- R6: Accepted fill words (`wr_valid` and `wr_ready`) that are kept are written to the writable bank at consecutive addresses starting from 0.
- R7: Sub-cubes are SUB_WORDS consecutive accepted words. If `wr_skip` is high on the first word of a sub-cube, all of its words are accepted but not written, and the fill address does not advance.
- R8: After the last bank address has been written, `wr_ready` stays low until a rotation.
- R9: In a cycle that rotates, `wr_ready` is low. After the rotation, filling restarts at address 0 of the new writable bank, at a sub-cube boundary, and overwrites that bank's earlier contents.
- R10: A read and an accepted fill word in the same cycle do not affect each other. The read still returns its data one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request |
| rd_bank | input | 2 | Bank to read (3 = no bank) |
| rd_addr | input | AW | Word address inside the bank |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | DW | Read data |
| wr_valid | input | 1 | Fill word present |
| wr_skip | input | 1 | On the first word of a sub-cube: drop this sub-cube |
| wr_data | input | DW | Fill word |
| wr_ready | output | 1 | Fill word accepted this cycle when high |
| bank_rd_ok | output | 3 | Readable-bank mask |
| bank_wr_sel | output | 2 | Index of the writable bank |
| rot_evt | output | 1 | One-cycle pulse after a rotation |

## Verification
The read path and the fill path can act in the same cycle. The bench drives both almost continuously: it reads the two readable banks while a full bank of sub-cubes, including a skipped one, streams into the third. A reference model is compared every cycle on `rd_valid`, `rd_data`, `wr_ready` and the role outputs. The hardest overlap is a read of the writable bank while a fill word is offered. Here the bench expects the word to be refused in that cycle, the roles to move, and the next accepted words to land at address 0 of the new writable bank. Later reads of that bank check this.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
    localparam int NBANK = 3;

    typedef enum logic [1:0] {
        ROLE_W2 = 2'd0,
        ROLE_W1 = 2'd1,
        ROLE_W0 = 2'd2
    } role_e;

    typedef enum logic [1:0] {
        F_EDGE = 2'd0,
        F_KEEP = 2'd1,
        F_DROP = 2'd2,
        F_FULL = 2'd3
    } fill_e;
endpackage

// File: rtl/tbc_bank_ram.sv
module tbc_bank_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/tbc_role_ctrl.sv
module tbc_role_ctrl
    import tbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rot,
    output logic [1:0] wr_sel,
    output logic [2:0] rd_ok,
    output logic       rot_evt
);
    role_e state, state_n;

    always_comb begin
        state_n = state;
        if (rot) begin
            unique case (state)
                ROLE_W2: state_n = ROLE_W1;
                ROLE_W1: state_n = ROLE_W0;
                ROLE_W0: state_n = ROLE_W2;
                default: state_n = ROLE_W2;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ROLE_W2;
            rot_evt <= 1'b0;
        end else begin
            state   <= state_n;
            rot_evt <= rot;
        end
    end

    always_comb begin
        unique case (state)
            ROLE_W2: begin wr_sel = 2'd2; rd_ok = 3'b011; end
            ROLE_W1: begin wr_sel = 2'd1; rd_ok = 3'b101; end
            ROLE_W0: begin wr_sel = 2'd0; rd_ok = 3'b110; end
            default: begin wr_sel = 2'd2; rd_ok = 3'b011; end
        endcase
    end

    // R2
    two_readable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rd_ok) == 2) && !rd_ok[wr_sel]);

    // R4
    rotate_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rot |=> (wr_sel == (($past(wr_sel) == 2'd0) ? 2'd2 : $past(wr_sel) - 2'd1)) && rot_evt);

    // R4
    hold_roles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rot |=> $stable(wr_sel) && !rot_evt);
endmodule

// File: rtl/tbc_fill_fsm.sv
module tbc_fill_fsm
    import tbc_pkg::*;
#(
    parameter int SUB_WORDS  = 8,
    parameter int BANK_WORDS = 128,
    parameter int AW         = $clog2(BANK_WORDS),
    parameter int BW         = $clog2(SUB_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rot,
    input  logic          wr_valid,
    input  logic          wr_skip,
    output logic          wr_ready,
    output logic          we,
    output logic [AW-1:0] waddr
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(BANK_WORDS - 1);
    localparam logic [BW-1:0] LAST_BEAT = BW'(SUB_WORDS - 1);

    fill_e         state, state_n;
    logic [AW-1:0] ptr, ptr_n;
    logic [BW-1:0] beat, beat_n;
    logic          acc;

    always_comb begin
        wr_ready = (state != F_FULL) && !rot;
        acc      = wr_valid && wr_ready;
        we       = acc && ((state == F_KEEP) || ((state == F_EDGE) && !wr_skip));
        waddr    = ptr;
    end

    always_comb begin
        state_n = state;
        ptr_n   = ptr;
        beat_n  = beat;
        unique case (state)
            F_EDGE: begin
                if (acc) begin
                    beat_n = BW'(1);
                    if (wr_skip) begin
                        state_n = F_DROP;
                    end else begin
                        state_n = F_KEEP;
                        ptr_n   = ptr + 1'b1;
                    end
                end
            end
            F_KEEP: begin
                if (acc) begin
                    ptr_n = (ptr == LAST_ADDR) ? '0 : ptr + 1'b1;
                    if (beat == LAST_BEAT) begin
                        beat_n  = '0;
                        state_n = (ptr == LAST_ADDR) ? F_FULL : F_EDGE;
                    end else begin
                        beat_n = beat + 1'b1;
                    end
                end
            end
            F_DROP: begin
                if (acc) begin
                    if (beat == LAST_BEAT) begin
                        beat_n  = '0;
                        state_n = F_EDGE;
                    end else begin
                        beat_n = beat + 1'b1;
                    end
                end
            end
            F_FULL: begin
                state_n = F_FULL;
            end
            default: state_n = F_EDGE;
        endcase
        if (rot) begin
            state_n = F_EDGE;
            ptr_n   = '0;
            beat_n  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= F_EDGE;
            ptr   <= '0;
            beat  <= '0;
        end else begin
            state <= state_n;
            ptr   <= ptr_n;
            beat  <= beat_n;
        end
    end

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rot |=> (ptr == '0) && (state == F_EDGE));

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_FULL) && !rot |=> (state == F_FULL));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (ptr != LAST_ADDR)) |=> (ptr == $past(ptr) + 1'b1));

    // R7
    drop_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_DROP) && !rot |=> $stable(ptr));
endmodule

// File: rtl/tribank_fill_cache.sv
module tribank_fill_cache
    import tbc_pkg::*;
#(
    parameter int DW         = 16,
    parameter int SUB_WORDS  = 8,
    parameter int BANK_SUBS  = 16,
    parameter int BANK_WORDS = SUB_WORDS * BANK_SUBS,
    parameter int AW         = $clog2(BANK_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [1:0]    rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          wr_valid,
    input  logic          wr_skip,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    output logic [2:0]    bank_rd_ok,
    output logic [1:0]    bank_wr_sel,
    output logic          rot_evt
);
    logic          rot_now;
    logic          fill_we;
    logic [AW-1:0] fill_addr;
    logic [DW-1:0] bank_q [NBANK];
    logic [NBANK-1:0] bank_we;
    logic          rd_valid_q;
    logic [1:0]    rd_bank_q;

    assign rot_now = rd_req && (rd_bank == bank_wr_sel);

    tbc_role_ctrl u_role (
        .clk     (clk),
        .rst_n   (rst_n),
        .rot     (rot_now),
        .wr_sel  (bank_wr_sel),
        .rd_ok   (bank_rd_ok),
        .rot_evt (rot_evt)
    );

    tbc_fill_fsm #(
        .SUB_WORDS  (SUB_WORDS),
        .BANK_WORDS (BANK_WORDS),
        .AW         (AW)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .rot      (rot_now),
        .wr_valid (wr_valid),
        .wr_skip  (wr_skip),
        .wr_ready (wr_ready),
        .we       (fill_we),
        .waddr    (fill_addr)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_we[b] = fill_we && (bank_wr_sel == 2'(b));
        tbc_bank_ram #(
            .DW    (DW),
            .DEPTH (BANK_WORDS),
            .AW    (AW)
        ) u_ram (
            .clk   (clk),
            .we    (bank_we[b]),
            .waddr (fill_addr),
            .wdata (wr_data),
            .re    (rd_req && (rd_bank == 2'(b))),
            .raddr (rd_addr),
            .rdata (bank_q[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_bank_q  <= 2'd0;
        end else begin
            rd_valid_q <= rd_req && (rd_bank != 2'd3);
            rd_bank_q  <= rd_bank;
        end
    end

    always_comb begin
        rd_valid = rd_valid_q;
        unique case (rd_bank_q)
            2'd0:    rd_data = bank_q[0];
            2'd1:    rd_data = bank_q[1];
            2'd2:    rd_data = bank_q[2];
            default: rd_data = '0;
        endcase
    end

    // R2
    write_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we & bank_rd_ok) == 3'b000);

    // R10
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (rd_bank != 2'd3)) |=> rd_valid);

    // R5
    bad_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (rd_bank == 2'd3)) |=> !rd_valid && $stable(bank_wr_sel));

    // R9
    rot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rot_now |-> !wr_ready && !fill_we);
endmodule

// File: tb/sim_tribank_fill_cache.sv
module sim_tribank_fill_cache;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 16;
    localparam int SW  = 4;
    localparam int BS  = 4;
    localparam int BWD = SW * BS;
    localparam int AW  = $clog2(BWD);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd_req;
    logic [1:0]    rd_bank;
    logic [AW-1:0] rd_addr;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          wr_valid;
    logic          wr_skip;
    logic [DW-1:0] wr_data;
    logic          wr_ready;
    logic [2:0]    bank_rd_ok;
    logic [1:0]    bank_wr_sel;
    logic          rot_evt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // reference model
    int m_mem [3][BWD];
    int m_wr, m_ptr, m_beat;
    bit m_full, m_drop;

    tribank_fill_cache #(.DW(DW), .SUB_WORDS(SW), .BANK_SUBS(BS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_skip(wr_skip), .wr_data(wr_data),
        .wr_ready(wr_ready), .bank_rd_ok(bank_rd_ok),
        .bank_wr_sel(bank_wr_sel), .rot_evt(rot_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    function automatic int mask_of(input int w);
        return 7 & ~(1 << w);
    endfunction

    // one clock cycle of stimulus, model update and comparison
    task automatic step(input bit rq, input int rb, input int ra,
                        input bit wv, input bit sk, input int wd);
        bit rot, rdy, acc, exp_v;
        int exp_d;
        string vtag;
        rd_req = rq; rd_bank = 2'(rb); rd_addr = AW'(ra);
        wr_valid = wv; wr_skip = sk; wr_data = DW'(wd);
        #1;
        rot = rq && (rb == m_wr);
        rdy = !m_full && !rot;
        check(rot ? "R9" : "R8", "wr_ready", int'(wr_ready), int'(rdy));
        exp_v = rq && (rb != 3);
        exp_d = exp_v ? m_mem[rb][ra] : -1;
        acc = wv && rdy;
        if (acc) begin
            if (m_beat == 0) m_drop = sk;
            if (!m_drop) begin
                m_mem[m_wr][m_ptr] = wd;
                m_ptr++;
            end
            m_beat++;
            if (m_beat == SW) begin
                m_beat = 0;
                if (m_ptr == BWD) m_full = 1;
            end
        end
        if (rot) begin
            m_wr = (m_wr + 2) % 3;
            m_ptr = 0; m_beat = 0; m_full = 0; m_drop = 0;
        end
        @(posedge clk);
        @(negedge clk);
        vtag = (rb == 3) ? "R5" : (acc ? "R10" : "R3");
        check(vtag, "rd_valid", int'(rd_valid), int'(exp_v));
        if (exp_v && exp_d >= 0)
            check("R3/R6/R7", "rd_data", int'(rd_data), exp_d);
        check("R4", "bank_wr_sel", int'(bank_wr_sel), m_wr);
        check("R2", "bank_rd_ok", int'(bank_rd_ok), mask_of(m_wr));
        check("R4", "rot_evt", int'(rot_evt), int'(rot));
    endtask

    initial begin
        for (int b = 0; b < 3; b++)
            for (int a = 0; a < BWD; a++)
                m_mem[b][a] = -1;
        m_wr = 2; m_ptr = 0; m_beat = 0; m_full = 0; m_drop = 0;
        rst_n = 0; rd_req = 0; rd_bank = 0; rd_addr = '0;
        wr_valid = 0; wr_skip = 0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        check("R1", "bank_wr_sel", int'(bank_wr_sel), 2);
        check("R1", "bank_rd_ok", int'(bank_rd_ok), 3);
        check("R1", "rd_valid", int'(rd_valid), 0);
        check("R1", "wr_ready", int'(wr_ready), 1);

        // fill bank 2: five sub-cubes, the second skipped (R6, R7), reads on banks 0/1 (R10)
        for (int s = 0; s < 5; s++)
            for (int w = 0; w < SW; w++)
                step(1, (s + w) % 2, w, 1, (s == 1) && (w == 0), 1000 + s * 16 + w);
        // bank full: offered words refused (R8)
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 7);
        // read bank 2: rotation, data back (R4); then read all of bank 2 while filling bank 1 (R10)
        step(1, 2, 5, 0, 0, 0);
        for (int a = 0; a < BWD; a++) step(1, 2, a, 1, 0, 2000 + a);
        for (int i = 0; i < 2; i++) step(0, 0, 0, 1, 0, 9);
        // read bank 1: rotation, writable becomes 0
        step(1, 1, 3, 0, 0, 0);
        // partial fill of bank 0 with reads on banks 1 and 2
        for (int a = 0; a < 6; a++) step(1, 1 + (a % 2), a + 8, 1, 0, 3000 + a);
        // R9: read bank 0 while a fill word is offered
        step(1, 0, 2, 1, 0, 4444);
        // new writable bank 2 restarts at address 0
        for (int a = 0; a < 3; a++) step(1, 0, a, 1, 0, 5000 + a);
        // R5: bank index 3 ignored
        for (int i = 0; i < 3; i++) step(1, 3, i, 0, 0, 0);
        // read bank 2: rotation, then read back restart words and older ones
        step(1, 2, 0, 0, 0, 0);
        for (int a = 0; a < 6; a++) step(1, 2, a, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule